// File: doc/BRIEF.md
# Keyed Configuration Port

This block is a configuration front end reached through two byte-wide I/O locations: an index location and a data location. Software selects a register by writing its number to the index location, then reads or writes that register through the data location. After reset the port is locked. While it is locked, register traffic has no effect. The port only opens after a fixed four-byte unlock key is written to the index location. The last key byte depends on the base I/O address the instance is strapped to.

Once the port is open, software can reach three kinds of register:

- Global registers: device select, clock source choice, multi-function pin control and watchdog setup.
- A bank of registers for each logical device, holding an enable flag and a 16-bit I/O base. The device-select register chooses which bank is visible.
- A control register. Writing the leave code to it locks the port again.

The block drives the stored configuration bits straight to its outputs. It also drives a registered active-low standby-switch output, which is gated by the pin-control register and two suspend inputs.

Top module: `keyed_cfg_port`

## Requirements
- R1: After synchronous reset the port is locked and the registers hold their defaults:
  - `cfg_mode`=0, `uart_clk_24`=0 (48 MHz selected), `wdt_cfg`=WDT_INIT (0x40), `wdt_active`=1.
  - Every `dev_en` bit and every `dev_base` bit is 0, and `standby_n`=1.
- R2: Writes to the index location unlock the port. The sequence is 0x87, 0x01, 0x55, then a last byte. The last byte is 0xAA when PORT_BASE is 0x4E and 0x55 for any other base. `cfg_mode` goes to 1 at the clock edge that takes the last byte, and a wrong last byte leaves the port locked.
- R3: A wrong byte during key entry drops the matcher back to its start. If that wrong byte is 0x87, it counts as the first key byte, so matching continues from the second step.
- R4: While the port is locked, data-location writes change no register, and reads of either location return 0xFF.
- R5: Writing 0x02 to register 0x02 locks the port (`cfg_mode` goes to 0 at that edge). Any other value written there keeps the port open, and register 0x02 reads as 0x00.
- R6: Register 0x07 holds the 8-bit device number, which reads back and selects the visible device bank.
- R7: Register 0x23 keeps only bit 0. It reads back as {7'b0, bit0}, and `uart_clk_24` follows bit 0 (1 means 24 MHz, 0 means 48 MHz).
- R8: Register 0x2A is a full 8-bit register. One cycle after bit 7 is 1 with `susp_a`=1 and `susp_b`=0, `standby_n` is 0. In every other case `standby_n` is 1 one cycle later.
- R9: Register 0x72 drives `wdt_cfg`. `wdt_active` is 1 when the register is non-zero, so writing 0x00 stops the watchdog.
- R10: Each device d below NDEV has its own registers in its bank:
  - an enable at 0x30 (bit 0);
  - base high byte at 0x60 and base low byte at 0x61.

  They appear on `dev_en[d]` and `dev_base[16*d +: 16]` as {high, low}.
- R11: Writes to 0x60 or 0x61 are ignored while the selected device's enable is set.
- R12: `io_rdata` updates at the edge that samples `io_rd` and holds until the next read. Unmapped registers read 0x00. When the device number is NDEV or above, the bank registers read 0x00 and writes to them are ignored.
- R13: While the port is open, a read of the index location returns the last index written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_rd | input | 1 | Read strobe, one cycle per byte |
| io_sel | input | 1 | 0 selects the index location, 1 selects the data location |
| io_wdata | input | 8 | Write byte |
| io_rdata | output | 8 | Registered read byte |
| cfg_mode | output | 1 | 1 while the port is open |
| susp_a | input | 1 | First suspend input |
| susp_b | input | 1 | Second suspend input |
| standby_n | output | 1 | Registered active-low standby switch |
| uart_clk_24 | output | 1 | Serial clock source choice, 1 = 24 MHz |
| wdt_cfg | output | 8 | Watchdog configuration byte |
| wdt_active | output | 1 | Watchdog configuration is non-zero |
| dev_en | output | NDEV | Per-device enable flags |
| dev_base | output | 16*NDEV | Per-device I/O bases, device d at bits 16*d+15..16*d |

## Verification
The assertions assume that `io_wr` and `io_rd` are never high in the same cycle. They also assume that both strobes are low while `rst` is high, so every window that starts just after reset begins from a quiet bus. The stimulus meets both assumptions: every bus access is a single-cycle task that raises one strobe just after a clock edge and drops it just after the next edge, and no access starts until reset has been released. A second instance strapped to base 0x4E shares the same bus. This lets both last-byte cases run against the same key traffic, and the assertions on that instance hold in the same way.

// File: rtl/kcp_pkg.sv
package kcp_pkg;
  localparam int BW = 8;
  localparam int KEY_LEN = 4;
  localparam int STEP_W = $clog2(KEY_LEN);

  localparam logic [BW-1:0] IDX_CTRL = 8'h02;
  localparam logic [BW-1:0] IDX_LDN  = 8'h07;
  localparam logic [BW-1:0] IDX_CLK  = 8'h23;
  localparam logic [BW-1:0] IDX_PIN  = 8'h2A;
  localparam logic [BW-1:0] IDX_WDT  = 8'h72;
  localparam logic [BW-1:0] IDX_EN   = 8'h30;
  localparam logic [BW-1:0] IDX_BHI  = 8'h60;
  localparam logic [BW-1:0] IDX_BLO  = 8'h61;

  localparam logic [BW-1:0] LEAVE_CODE = 8'h02;
  localparam logic [BW-1:0] KEY_START  = 8'h87;
  localparam logic [BW-1:0] LOCKED_RD  = 8'hFF;

  function automatic logic [BW-1:0] key_tail(input logic [15:0] base);
    return (base == 16'h004E) ? 8'hAA : 8'h55;
  endfunction

  function automatic logic [BW-1:0] key_byte(input logic [STEP_W-1:0] step,
                                             input logic [BW-1:0] tail);
    case (step)
      2'd0:    return KEY_START;
      2'd1:    return 8'h01;
      2'd2:    return 8'h55;
      default: return tail;
    endcase
  endfunction
endpackage

// File: rtl/kcp_key_match.sv
module kcp_key_match
  import kcp_pkg::*;
#(
  parameter logic [BW-1:0] TAIL = 8'h55
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          idx_wr,
  input  logic [BW-1:0] wbyte,
  input  logic          leave,
  output logic          cfg_mode
);
  logic [STEP_W-1:0] step;
  logic [BW-1:0]     want;

  assign want = key_byte(step, TAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_mode <= 1'b0;
      step     <= '0;
    end else if (cfg_mode) begin
      if (leave) begin
        cfg_mode <= 1'b0;
        step     <= '0;
      end
    end else if (idx_wr) begin
      if (wbyte == want) begin
        if (step == STEP_W'(KEY_LEN - 1)) begin
          cfg_mode <= 1'b1;
          step     <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end else if (wbyte == KEY_START) begin
        step <= STEP_W'(1);
      end else begin
        step <= '0;
      end
    end
  end
endmodule

// File: rtl/kcp_glob_regs.sv
module kcp_glob_regs
  import kcp_pkg::*;
#(
  parameter logic [BW-1:0] WDT_INIT = 8'h40
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_mode,
  input  logic          idx_wr,
  input  logic          dat_wr,
  input  logic [BW-1:0] wbyte,
  output logic [BW-1:0] cur_idx,
  output logic [BW-1:0] ldn_q,
  output logic          clk24_q,
  output logic [BW-1:0] pin_q,
  output logic [BW-1:0] wdt_q,
  output logic          leave
);
  assign leave = dat_wr && (cur_idx == IDX_CTRL) && (wbyte == LEAVE_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_idx <= '0;
    end else if (idx_wr && cfg_mode) begin
      cur_idx <= wbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ldn_q   <= '0;
      clk24_q <= 1'b0;
      pin_q   <= '0;
      wdt_q   <= WDT_INIT;
    end else if (dat_wr) begin
      case (cur_idx)
        IDX_LDN: ldn_q   <= wbyte;
        IDX_CLK: clk24_q <= wbyte[0];
        IDX_PIN: pin_q   <= wbyte;
        IDX_WDT: wdt_q   <= wbyte;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/kcp_dev_banks.sv
module kcp_dev_banks
  import kcp_pkg::*;
#(
  parameter int NDEV   = 8,
  parameter int BASE_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   dat_wr,
  input  logic [BW-1:0]          cur_idx,
  input  logic [BW-1:0]          ldn,
  input  logic [BW-1:0]          wbyte,
  output logic [NDEV-1:0]        en_q,
  output logic [NDEV*BASE_W-1:0] base_q,
  output logic [BW-1:0]          rd_bank
);
  localparam int HALF = BASE_W / 2;

  logic [HALF-1:0] hi_q [NDEV];
  logic [HALF-1:0] lo_q [NDEV];

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    logic hit;
    assign hit = dat_wr && (ldn == BW'(d));

    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[d] <= 1'b0;
        hi_q[d] <= '0;
        lo_q[d] <= '0;
      end else if (hit) begin
        case (cur_idx)
          IDX_EN:  en_q[d] <= wbyte[0];
          IDX_BHI: if (!en_q[d]) hi_q[d] <= wbyte[HALF-1:0];
          IDX_BLO: if (!en_q[d]) lo_q[d] <= wbyte[HALF-1:0];
          default: ;
        endcase
      end
    end

    assign base_q[d*BASE_W +: BASE_W] = {hi_q[d], lo_q[d]};
  end

  always_comb begin
    rd_bank = '0;
    for (int d = 0; d < NDEV; d++) begin
      if (ldn == BW'(d)) begin
        case (cur_idx)
          IDX_EN:  rd_bank = {{(BW-1){1'b0}}, en_q[d]};
          IDX_BHI: rd_bank = BW'(hi_q[d]);
          IDX_BLO: rd_bank = BW'(lo_q[d]);
          default: rd_bank = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
  import kcp_pkg::*;
#(
  parameter int              NDEV      = 8,
  parameter int              BASE_W    = 16,
  parameter logic [15:0]     PORT_BASE = 16'h002E,
  parameter logic [BW-1:0]   WDT_INIT  = 8'h40
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   io_wr,
  input  logic                   io_rd,
  input  logic                   io_sel,
  input  logic [BW-1:0]          io_wdata,
  output logic [BW-1:0]          io_rdata,
  output logic                   cfg_mode,
  input  logic                   susp_a,
  input  logic                   susp_b,
  output logic                   standby_n,
  output logic                   uart_clk_24,
  output logic [BW-1:0]          wdt_cfg,
  output logic                   wdt_active,
  output logic [NDEV-1:0]        dev_en,
  output logic [NDEV*BASE_W-1:0] dev_base
);
  localparam logic [BW-1:0] TAIL = key_tail(PORT_BASE);

  logic          idx_wr, dat_wr, leave;
  logic [BW-1:0] cur_idx, ldn_q, pin_q, rd_bank, rd_mux;

  assign idx_wr = io_wr && !io_sel;
  assign dat_wr = io_wr && io_sel && cfg_mode;

  kcp_key_match #(.TAIL(TAIL)) u_key (
    .clk(clk), .rst(rst), .idx_wr(idx_wr), .wbyte(io_wdata),
    .leave(leave), .cfg_mode(cfg_mode)
  );

  kcp_glob_regs #(.WDT_INIT(WDT_INIT)) u_glob (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .idx_wr(idx_wr),
    .dat_wr(dat_wr), .wbyte(io_wdata), .cur_idx(cur_idx), .ldn_q(ldn_q),
    .clk24_q(uart_clk_24), .pin_q(pin_q), .wdt_q(wdt_cfg), .leave(leave)
  );

  kcp_dev_banks #(.NDEV(NDEV), .BASE_W(BASE_W)) u_banks (
    .clk(clk), .rst(rst), .dat_wr(dat_wr), .cur_idx(cur_idx),
    .ldn(ldn_q), .wbyte(io_wdata), .en_q(dev_en), .base_q(dev_base),
    .rd_bank(rd_bank)
  );

  assign wdt_active = (wdt_cfg != '0);

  always_comb begin
    case (cur_idx)
      IDX_LDN:                   rd_mux = ldn_q;
      IDX_CLK:                   rd_mux = {{(BW-1){1'b0}}, uart_clk_24};
      IDX_PIN:                   rd_mux = pin_q;
      IDX_WDT:                   rd_mux = wdt_cfg;
      IDX_EN, IDX_BHI, IDX_BLO:  rd_mux = rd_bank;
      default:                   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rdata <= LOCKED_RD;
    end else if (io_rd) begin
      if (!cfg_mode)    io_rdata <= LOCKED_RD;
      else if (!io_sel) io_rdata <= cur_idx;
      else              io_rdata <= rd_mux;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) standby_n <= 1'b1;
    else     standby_n <= !(pin_q[BW-1] && susp_a && !susp_b);
  end
endmodule

// File: rtl/kcp_chk.sv
module kcp_chk #(
  parameter int NDEV = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            io_wr,
  input logic            io_rd,
  input logic            io_sel,
  input logic [7:0]      io_wdata,
  input logic [7:0]      io_rdata,
  input logic            cfg_mode,
  input logic [7:0]      idx,
  input logic            pin7,
  input logic            susp_a,
  input logic            susp_b,
  input logic            standby_n,
  input logic            uart_clk_24,
  input logic [7:0]      wdt_cfg,
  input logic [NDEV-1:0] dev_en
);
  // R4
  locked_read_ff_chk: assert property (@(posedge clk) disable iff (rst)
    io_rd && !cfg_mode |=> io_rdata == 8'hFF);

  // R4
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    io_wr && io_sel && !cfg_mode |=>
      $stable(uart_clk_24) && $stable(wdt_cfg) && $stable(dev_en));

  // R2
  unlock_from_index_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_mode) |-> $past(io_wr && !io_sel));

  // R5
  leave_code_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_mode && io_wr && io_sel && idx == 8'h02 && io_wdata == 8'h02 |=> !cfg_mode);

  // R5
  ctrl_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_mode && io_rd && io_sel && idx == 8'h02 |=> io_rdata == 8'h00);

  // R8
  standby_on_chk: assert property (@(posedge clk) disable iff (rst)
    pin7 && susp_a && !susp_b |=> !standby_n);

  // R8
  standby_off_chk: assert property (@(posedge clk) disable iff (rst)
    !pin7 |=> standby_n);
endmodule

bind keyed_cfg_port kcp_chk #(.NDEV(NDEV)) u_chk (
  .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_mode(cfg_mode),
  .idx(cur_idx), .pin7(pin_q[7]), .susp_a(susp_a), .susp_b(susp_b),
  .standby_n(standby_n), .uart_clk_24(uart_clk_24), .wdt_cfg(wdt_cfg),
  .dev_en(dev_en)
);

// File: tb/keyed_cfg_port_test.sv
module keyed_cfg_port_test;
  localparam int NDEV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic io_wr = 1'b0, io_rd = 1'b0, io_sel = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic susp_a = 1'b0, susp_b = 1'b0;

  logic [7:0] io_rdata, io_rdata4, wdt_cfg, wdt_cfg4;
  logic cfg_mode, cfg_mode4, standby_n, standby_n4;
  logic uart_clk_24, uart_clk_244, wdt_active, wdt_active4;
  logic [NDEV-1:0] dev_en, dev_en4;
  logic [NDEV*16-1:0] dev_base, dev_base4;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  keyed_cfg_port #(.NDEV(NDEV), .PORT_BASE(16'h002E)) uut (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_mode(cfg_mode),
    .susp_a(susp_a), .susp_b(susp_b), .standby_n(standby_n),
    .uart_clk_24(uart_clk_24), .wdt_cfg(wdt_cfg), .wdt_active(wdt_active),
    .dev_en(dev_en), .dev_base(dev_base)
  );

  keyed_cfg_port #(.NDEV(NDEV), .PORT_BASE(16'h004E)) uut4e (
    .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_sel(io_sel),
    .io_wdata(io_wdata), .io_rdata(io_rdata4), .cfg_mode(cfg_mode4),
    .susp_a(susp_a), .susp_b(susp_b), .standby_n(standby_n4),
    .uart_clk_24(uart_clk_244), .wdt_cfg(wdt_cfg4), .wdt_active(wdt_active4),
    .dev_en(dev_en4), .dev_base(dev_base4)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [7:0] b);
    io_sel = sel; io_wdata = b; io_wr = 1'b1;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic sel, output logic [7:0] v);
    io_sel = sel; io_rd = 1'b1;
    @(posedge clk); #1;
    io_rd = 1'b0;
    v = io_rdata;
  endtask

  task automatic setreg(input logic [7:0] i, input logic [7:0] v);
    bus_wr(1'b0, i);
    bus_wr(1'b1, v);
  endtask

  task automatic getreg(input logic [7:0] i, output logic [7:0] v);
    bus_wr(1'b0, i);
    bus_rd(1'b1, v);
  endtask

  task automatic key4(input logic [7:0] last);
    bus_wr(1'b0, 8'h87); bus_wr(1'b0, 8'h01);
    bus_wr(1'b0, 8'h55); bus_wr(1'b0, last);
  endtask

  function automatic logic [15:0] base_of(input int d);
    return 16'h0200 + 16'(d) * 16'h0108;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state
    chk("R1 cfg_mode", 16'(cfg_mode), 16'h0);
    chk("R1 uart_clk_24", 16'(uart_clk_24), 16'h0);
    chk("R1 wdt_cfg", 16'(wdt_cfg), 16'h0040);
    chk("R1 wdt_active", 16'(wdt_active), 16'h1);
    chk("R1 dev_en", 16'(dev_en), 16'h0);
    chk("R1 dev_base", 16'(|dev_base), 16'h0);
    chk("R1 standby_n", 16'(standby_n), 16'h1);

    // R4 locked: writes ignored, reads 0xFF
    bus_wr(1'b0, 8'h23); bus_wr(1'b1, 8'h01);
    bus_wr(1'b0, 8'h72); bus_wr(1'b1, 8'h00);
    chk("R4 clk unchanged", 16'(uart_clk_24), 16'h0);
    chk("R4 wdt unchanged", 16'(wdt_cfg), 16'h0040);
    bus_rd(1'b1, v); chk("R4 data read", 16'(v), 16'h00FF);
    bus_rd(1'b0, v); chk("R4 index read", 16'(v), 16'h00FF);

    // R2 tail byte depends on strapped base
    key4(8'hAA);
    chk("R2 base2E rejects AA", 16'(cfg_mode), 16'h0);
    chk("R2 base4E accepts AA", 16'(cfg_mode4), 16'h1);
    key4(8'h55);
    chk("R2 base2E accepts 55", 16'(cfg_mode), 16'h1);

    // R13 index readback
    bus_wr(1'b0, 8'h23); bus_rd(1'b0, v);
    chk("R13 index read", 16'(v), 16'h0023);

    // R5 leave only on code 0x02
    setreg(8'h02, 8'h05);
    chk("R5 other value stays open", 16'(cfg_mode), 16'h1);
    getreg(8'h02, v); chk("R5 ctrl reads zero", 16'(v), 16'h0);
    setreg(8'h02, 8'h02);
    chk("R5 leave code locks", 16'(cfg_mode), 16'h0);

    // R3 wrong byte resets; 0x87 restarts at second step
    bus_wr(1'b0, 8'h87); bus_wr(1'b0, 8'h01); bus_wr(1'b0, 8'h33);
    bus_wr(1'b0, 8'h01); bus_wr(1'b0, 8'h55); bus_wr(1'b0, 8'h55);
    chk("R3 wrong byte resets", 16'(cfg_mode), 16'h0);
    bus_wr(1'b0, 8'h87); bus_wr(1'b0, 8'h87);
    bus_wr(1'b0, 8'h01); bus_wr(1'b0, 8'h55); bus_wr(1'b0, 8'h55);
    chk("R3 repeated start", 16'(cfg_mode), 16'h1);
    setreg(8'h02, 8'h02);
    bus_wr(1'b0, 8'h87); bus_wr(1'b0, 8'h01); bus_wr(1'b0, 8'h55);
    bus_wr(1'b0, 8'h87); bus_wr(1'b0, 8'h01); bus_wr(1'b0, 8'h55);
    chk("R3 start at last step not yet open", 16'(cfg_mode), 16'h0);
    bus_wr(1'b0, 8'h55);
    chk("R3 start at last step restarts", 16'(cfg_mode), 16'h1);

    // R7 sweep of clock select
    for (int x = 0; x < 256; x++) begin
      setreg(8'h23, 8'(x));
      chk("R7 uart_clk_24", 16'(uart_clk_24), 16'(x & 1));
      getreg(8'h23, v);
      chk("R7 readback", 16'(v), 16'(x & 1));
    end

    // R9 watchdog
    setreg(8'h72, 8'h5A);
    chk("R9 wdt_cfg", 16'(wdt_cfg), 16'h005A);
    chk("R9 active", 16'(wdt_active), 16'h1);
    setreg(8'h72, 8'h00);
    chk("R9 disabled", 16'(wdt_active), 16'h0);
    getreg(8'h72, v); chk("R9 readback", 16'(v), 16'h0);

    // R8 standby switch over every input combination
    for (int c = 0; c < 8; c++) begin
      logic [7:0] pv;
      pv = ((c >> 2) & 1) != 0 ? 8'h91 : 8'h11;
      setreg(8'h2A, pv);
      susp_a = c[0]; susp_b = c[1];
      @(posedge clk); #1;
      chk("R8 standby_n", 16'(standby_n),
          16'(!(pv[7] && c[0] && !c[1])));
      getreg(8'h2A, v); chk("R8 readback", 16'(v), 16'(pv));
    end
    susp_a = 1'b0; susp_b = 1'b0;

    // R6 R10 program every device bank
    for (int d = 0; d < NDEV; d++) begin
      logic [15:0] b;
      b = base_of(d);
      setreg(8'h07, 8'(d));
      getreg(8'h07, v); chk("R6 ldn readback", 16'(v), 16'(d));
      setreg(8'h30, 8'h00);
      setreg(8'h60, b[15:8]);
      setreg(8'h61, b[7:0]);
      setreg(8'h30, 8'h01);
    end
    chk("R10 all enabled", 16'(dev_en), 16'(8'hFF));
    for (int d = 0; d < NDEV; d++) begin
      chk("R10 dev_base", dev_base[16*d +: 16], base_of(d));
      setreg(8'h07, 8'(d));
      getreg(8'h60, v); chk("R6 bank hi", 16'(v), 16'(base_of(d) >> 8));
      getreg(8'h61, v); chk("R6 bank lo", 16'(v), 16'(base_of(d) & 16'hFF));
      getreg(8'h30, v); chk("R10 enable read", 16'(v), 16'h1);
    end

    // R11 base locked while enabled
    setreg(8'h07, 8'h03);
    setreg(8'h60, 8'hEE); setreg(8'h61, 8'hEE);
    chk("R11 base kept", dev_base[16*3 +: 16], base_of(3));
    getreg(8'h60, v); chk("R11 hi readback", 16'(v), 16'(base_of(3) >> 8));

    // R12 out-of-range device and unmapped index
    setreg(8'h07, 8'h09);
    getreg(8'h30, v); chk("R12 oob enable", 16'(v), 16'h0);
    getreg(8'h60, v); chk("R12 oob hi", 16'(v), 16'h0);
    setreg(8'h30, 8'h00);
    chk("R12 oob write ignored", 16'(dev_en), 16'(8'hFF));
    getreg(8'h55, v); chk("R12 unmapped", 16'(v), 16'h0);
    bus_wr(1'b0, 8'h07);
    repeat (3) @(posedge clk); #1;
    chk("R12 rdata holds", 16'(io_rdata), 16'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule